// File: doc/BRIEF.md
# Two-Wire Bus Transaction Sequencer

This block runs a whole short two-wire bus transaction on its own once software has written one control word. A transaction is either a write phase, a read phase, or a write phase followed by a read phase. Each phase moves one to eight bytes. The control word packs several fields: the target address (7-bit or 10-bit), the two phase lengths, and a choice of how the phases are joined. The join is either a repeated start or a stop followed by a fresh start.

Bytes to transmit come from two 32-bit words. Received bytes are packed into two 32-bit words in the same lane order. The block does not generate bit-level bus timing. It issues byte-level commands to a bus engine underneath and waits for each command's completion and acknowledge result. When the transaction finishes, the block raises a completion cause flag. If the target refused any byte, it also raises an error flag. Software acknowledges by writing zero to the control word.

Top module: `i2c_xfer_engine`

## Requirements
- R1: A control write starts a transaction only when bit 19 (enable) is set and at least one of bit 0 (write phase) or bit 1 (read phase) is set. The block must also be idle with the cause flag clear. The control word carries further fields: the address in bits 11:2, 10-bit addressing in bit 12, the write length minus one in bits 15:13, the read length minus one in bits 18:16, and repeated start in bit 20.
- R2: Commands are encoded on `cmd_op` as 1 start, 2 repeated start, 3 send byte, 4 receive byte and acknowledge, 5 receive byte and refuse, 6 stop. A command stays valid and unchanged until a cycle with `resp_valid` high completes it.
- R3: The address header byte depends on the addressing mode. With 7-bit addressing it is {address[6:0], dir}. With 10-bit addressing it is {5'b11110, address[9:8], dir} and is followed by a send of address[7:0]. In both modes dir is 0 for the write phase and 1 for the read phase.
- R4: The write phase sends (length field + 1) bytes. Byte k is taken from bits 8k+7:8k of {tx_hi, tx_lo}.
- R5: The read phase receives (length field + 1) bytes. Every byte except the last uses code 4 and the last uses code 5. Byte k is stored in bits 8k+7:8k of {rx_hi, rx_lo}, and lanes not received read zero because the receive words are cleared at launch.
- R6: A combined transfer runs the write phase first. If bit 20 is set, it then issues a repeated start. Otherwise it issues a stop followed by a start. The read phase follows, with its own header.
- R7: Each transaction ends with a stop command. When that stop completes, `busy` falls and `cause` rises in the same cycle.
- R8: If any sent byte (header, second address byte or data) is answered without acknowledge, the next command is a stop. No further bytes are moved, and the transaction ends with both `cause` and `status_err` set.
- R9: A nonzero control write while `busy` or `cause` is high is ignored. The running transaction and its settings are unchanged, and no new transaction starts.
- R10: Writing zero to the control word clears `cause` and `status_err`.
- R11: A control write with the enable bit clear, or with neither phase bit set, is ignored.
- R12: After reset, `busy`, `cause`, `status_err`, `cmd_valid` and both receive words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word value |
| tx_lo | input | 32 | Transmit bytes 0 to 3 |
| tx_hi | input | 32 | Transmit bytes 4 to 7 |
| rx_lo | output | 32 | Received bytes 0 to 3 |
| rx_hi | output | 32 | Received bytes 4 to 7 |
| status_err | output | 1 | Last transaction met a refused byte |
| cause | output | 1 | Transaction finished, awaiting acknowledge |
| busy | output | 1 | Transaction in progress |
| cmd_valid | output | 1 | Byte-level command pending |
| cmd_op | output | 3 | Command code |
| cmd_byte | output | 8 | Byte to send for code 3 |
| resp_valid | input | 1 | Current command completed |
| resp_ack | input | 1 | Sent byte was acknowledged |
| resp_byte | input | 8 | Byte received for codes 4 and 5 |

## Verification
Several rules are checked by assertions on every cycle. A command holds steady until it completes. A refused byte is followed at once by a stop. The settings stay frozen while the block is busy. The cause flag only rises as a busy transaction ends. The receive words are cleared at launch, and no command is issued while the cause flag is pending.

Other behaviour can only be shown by the bench scenarios. These cover the exact command order for each mode: 7-bit and 10-bit headers, repeated start against stop-then-start, and the acknowledge pattern on reads. They also cover the byte-lane placement in the receive words, a refusal at the header versus at a data byte, and the ignored control writes.

// File: rtl/i2c_xfer_pkg.sv
package i2c_xfer_pkg;

    localparam int XFER_REG_W     = 32;
    localparam int XFER_BYTE_W    = 8;
    localparam int XFER_MAX_BYTES = 8;
    localparam int XFER_LEN_W     = $clog2(XFER_MAX_BYTES);
    localparam int XFER_ADDR_W    = 10;
    localparam int XFER_BUF_W     = XFER_MAX_BYTES * XFER_BYTE_W;

    // control word bit positions
    localparam int CB_WR    = 0;
    localparam int CB_RD    = 1;
    localparam int CB_ADDR  = 2;
    localparam int CB_TEN   = 12;
    localparam int CB_TXLEN = 13;
    localparam int CB_RXLEN = 16;
    localparam int CB_EN    = 19;
    localparam int CB_RS    = 20;
    localparam int CB_TOP   = 21;

    typedef enum logic [2:0] {
        OP_NONE      = 3'd0,
        OP_START     = 3'd1,
        OP_RESTART   = 3'd2,
        OP_WRITE     = 3'd3,
        OP_READ_ACK  = 3'd4,
        OP_READ_NACK = 3'd5,
        OP_STOP      = 3'd6
    } bus_op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_RESTART, S_HDR, S_ADDR2,
        S_WDATA, S_MIDSTOP, S_RDATA, S_STOP
    } seq_state_e;

    typedef struct packed {
        logic                   rs;
        logic [XFER_LEN_W-1:0]  rx_last;
        logic [XFER_LEN_W-1:0]  tx_last;
        logic                   ten;
        logic [XFER_ADDR_W-1:0] addr;
        logic                   do_rd;
        logic                   do_wr;
    } xfer_cfg_t;

    function automatic xfer_cfg_t cfg_decode(input logic [XFER_REG_W-1:0] w);
        xfer_cfg_t c;
        c.do_wr   = w[CB_WR];
        c.do_rd   = w[CB_RD];
        c.addr    = w[CB_ADDR +: XFER_ADDR_W];
        c.ten     = w[CB_TEN];
        c.tx_last = w[CB_TXLEN +: XFER_LEN_W];
        c.rx_last = w[CB_RXLEN +: XFER_LEN_W];
        c.rs      = w[CB_RS];
        return c;
    endfunction

    function automatic logic [XFER_BYTE_W-1:0] header_byte(input xfer_cfg_t c, input logic dir);
        if (c.ten)
            return {5'b11110, c.addr[9:8], dir};
        else
            return {c.addr[6:0], dir};
    endfunction

endpackage

// File: rtl/i2c_xfer_regs.sv
module i2c_xfer_regs
    import i2c_xfer_pkg::*;
#(
    parameter int REG_W = XFER_REG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic [REG_W-1:0] ctl_wdata,
    input  logic             busy,
    input  logic             done,
    input  logic             fail,
    output logic             launch,
    output xfer_cfg_t        cfg_q,
    output logic             cause_q,
    output logic             err_q
);

    logic unused_hi_bits;
    assign unused_hi_bits = ^ctl_wdata[REG_W-1:CB_TOP];

    logic wr_zero;
    assign wr_zero = ctl_we && (ctl_wdata == '0);
    assign launch  = ctl_we && ctl_wdata[CB_EN] && (ctl_wdata[CB_WR] || ctl_wdata[CB_RD])
                     && !busy && !cause_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            cause_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (launch)
                cfg_q <= cfg_decode(ctl_wdata);
            if (done) begin
                cause_q <= 1'b1;
                err_q   <= fail;
            end else if (wr_zero) begin
                cause_q <= 1'b0;
                err_q   <= 1'b0;
            end
        end
    end

    // R9: settings frozen for the whole transaction
    a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cfg_q));

    // R7: completion flag only rises as a busy transaction ends
    a_r7_cause_after_busy: assert property (@(posedge clk) disable iff (rst)
        $rose(cause_q) |-> $past(busy));

endmodule

// File: rtl/i2c_xfer_bytebuf.sv
module i2c_xfer_bytebuf
    import i2c_xfer_pkg::*;
#(
    parameter int LANES  = XFER_MAX_BYTES,
    parameter int BYTE_W = XFER_BYTE_W,
    localparam int IDX_W = $clog2(LANES),
    localparam int BUF_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic [BUF_W-1:0]  tx_in,
    input  logic [IDX_W-1:0]  idx,
    input  logic              rd_store,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [BUF_W-1:0]  rx_all
);

    logic [BYTE_W-1:0] tx_lane [LANES];
    logic [BYTE_W-1:0] rx_lane [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                tx_lane[g] <= '0;
                rx_lane[g] <= '0;
            end else if (launch) begin
                tx_lane[g] <= tx_in[g*BYTE_W +: BYTE_W];
                rx_lane[g] <= '0;
            end else if (rd_store && (idx == IDX_W'(g))) begin
                rx_lane[g] <= rd_byte;
            end
        end
        assign rx_all[g*BYTE_W +: BYTE_W] = rx_lane[g];
    end

    assign tx_byte = tx_lane[idx];

    // R5: receive words start clean for every transaction
    a_r5_rx_cleared: assert property (@(posedge clk) disable iff (rst)
        launch |=> (rx_all == '0));

endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
    import i2c_xfer_pkg::*;
#(
    parameter int LEN_W  = XFER_LEN_W,
    parameter int BYTE_W = XFER_BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  xfer_cfg_t         cfg,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              resp_valid,
    input  logic              resp_ack,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [BYTE_W-1:0] cmd_byte,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [LEN_W-1:0]  idx,
    output logic              rd_store
);

    seq_state_e st;
    logic       phase_rd;
    logic       failed_q;
    bus_op_e    op;

    always_comb begin
        op       = OP_NONE;
        cmd_byte = '0;
        case (st)
            S_START:   op = OP_START;
            S_RESTART: op = OP_RESTART;
            S_HDR: begin
                op       = OP_WRITE;
                cmd_byte = header_byte(cfg, phase_rd);
            end
            S_ADDR2: begin
                op       = OP_WRITE;
                cmd_byte = cfg.addr[7:0];
            end
            S_WDATA: begin
                op       = OP_WRITE;
                cmd_byte = tx_byte;
            end
            S_RDATA:   op = (idx == cfg.rx_last) ? OP_READ_NACK : OP_READ_ACK;
            S_MIDSTOP, S_STOP: op = OP_STOP;
            default:   op = OP_NONE;
        endcase
    end

    assign cmd_op    = op;
    assign cmd_valid = (st != S_IDLE);
    assign busy      = (st != S_IDLE);
    assign done      = (st == S_STOP) && resp_valid;
    assign fail      = failed_q;
    assign rd_store  = (st == S_RDATA) && resp_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            phase_rd <= 1'b0;
            failed_q <= 1'b0;
            idx      <= '0;
        end else begin
            case (st)
                S_IDLE: if (launch) begin
                    st       <= S_START;
                    phase_rd <= 1'b0;
                    failed_q <= 1'b0;
                    idx      <= '0;
                end
                S_START: if (resp_valid) begin
                    st <= S_HDR;
                    if (!cfg.do_wr) phase_rd <= 1'b1;
                end
                S_RESTART: if (resp_valid) st <= S_HDR;
                S_HDR, S_ADDR2: if (resp_valid) begin
                    if (!resp_ack) begin
                        failed_q <= 1'b1;
                        st       <= S_STOP;
                    end else if (st == S_HDR && cfg.ten) begin
                        st <= S_ADDR2;
                    end else begin
                        idx <= '0;
                        st  <= phase_rd ? S_RDATA : S_WDATA;
                    end
                end
                S_WDATA: if (resp_valid) begin
                    if (!resp_ack) begin
                        failed_q <= 1'b1;
                        st       <= S_STOP;
                    end else if (idx == cfg.tx_last) begin
                        idx <= '0;
                        if (cfg.do_rd) begin
                            phase_rd <= 1'b1;
                            st       <= cfg.rs ? S_RESTART : S_MIDSTOP;
                        end else begin
                            st <= S_STOP;
                        end
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                S_MIDSTOP: if (resp_valid) st <= S_START;
                S_RDATA: if (resp_valid) begin
                    if (idx == cfg.rx_last) st <= S_STOP;
                    else                    idx <= idx + 1'b1;
                end
                S_STOP: if (resp_valid) st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    // R2: a pending command is held unchanged until completed
    a_r2_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !resp_valid) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_byte)));

    // R8: a refused byte is followed directly by a stop
    a_r8_nack_stop: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_ack && cmd_op == OP_WRITE) |=> (cmd_valid && cmd_op == OP_STOP));

    // R7: completing the final stop releases the block
    a_r7_stop_ends: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && st == S_STOP) |=> !busy);

endmodule

// File: rtl/i2c_xfer_engine.sv
module i2c_xfer_engine
    import i2c_xfer_pkg::*;
#(
    parameter int REG_W  = XFER_REG_W,
    parameter int BYTE_W = XFER_BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [REG_W-1:0]  ctl_wdata,
    input  logic [REG_W-1:0]  tx_lo,
    input  logic [REG_W-1:0]  tx_hi,
    output logic [REG_W-1:0]  rx_lo,
    output logic [REG_W-1:0]  rx_hi,
    output logic              status_err,
    output logic              cause,
    output logic              busy,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [BYTE_W-1:0] cmd_byte,
    input  logic              resp_valid,
    input  logic              resp_ack,
    input  logic [BYTE_W-1:0] resp_byte
);

    localparam int BUF_W = 2 * REG_W;
    localparam int LANES = BUF_W / BYTE_W;
    localparam int IDX_W = $clog2(LANES);

    logic              launch;
    xfer_cfg_t         cfg_q;
    logic              done;
    logic              fail;
    logic [IDX_W-1:0]  idx;
    logic              rd_store;
    logic [BYTE_W-1:0] tx_byte;
    logic [BUF_W-1:0]  rx_all;

    i2c_xfer_regs #(.REG_W(REG_W)) u_regs (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .busy(busy), .done(done), .fail(fail), .launch(launch),
        .cfg_q(cfg_q), .cause_q(cause), .err_q(status_err)
    );

    i2c_xfer_seq #(.LEN_W(IDX_W), .BYTE_W(BYTE_W)) u_seq (
        .clk(clk), .rst(rst), .launch(launch), .cfg(cfg_q), .tx_byte(tx_byte),
        .resp_valid(resp_valid), .resp_ack(resp_ack), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_byte(cmd_byte), .busy(busy), .done(done),
        .fail(fail), .idx(idx), .rd_store(rd_store)
    );

    i2c_xfer_bytebuf #(.LANES(LANES), .BYTE_W(BYTE_W)) u_buf (
        .clk(clk), .rst(rst), .launch(launch), .tx_in({tx_hi, tx_lo}),
        .idx(idx), .rd_store(rd_store), .rd_byte(resp_byte),
        .tx_byte(tx_byte), .rx_all(rx_all)
    );

    assign rx_lo = rx_all[REG_W-1:0];
    assign rx_hi = rx_all[BUF_W-1:REG_W];

    // R9: nothing reaches the bus while completion is unacknowledged
    a_r9_quiet_pending: assert property (@(posedge clk) disable iff (rst)
        cause |-> !cmd_valid);

endmodule

// File: tb/sim_i2c_xfer_engine.sv
module sim_i2c_xfer_engine;
    import i2c_xfer_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst, ctl_we, resp_valid, resp_ack;
    logic [31:0] ctl_wdata, tx_lo, tx_hi, rx_lo, rx_hi;
    logic        status_err, cause, busy, cmd_valid;
    logic [2:0]  cmd_op;
    logic [7:0]  cmd_byte, resp_byte;

    i2c_xfer_engine u0 (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .tx_lo(tx_lo), .tx_hi(tx_hi), .rx_lo(rx_lo), .rx_hi(rx_hi),
        .status_err(status_err), .cause(cause), .busy(busy),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
        .resp_valid(resp_valid), .resp_ack(resp_ack), .resp_byte(resp_byte)
    );

    int checks = 0;
    int errors = 0;

    // observed and expected command logs
    logic [2:0] logop [64];
    logic [7:0] logbyte [64];
    int logn, wrcnt, rdcnt, nack_at;
    logic [2:0] expop [64];
    logic [7:0] expbyte [64];
    int expn, expw;
    bit ended;

    // vector: wr rd ten rs addr[10] txl[3] rxl[3] nack[4] tx[64]
    localparam int NV = 9;
    localparam logic [87:0] VEC [NV] = '{
        {1'b1,1'b0,1'b0,1'b0,10'h050,3'd2,3'd0,4'd0,64'h1122334455667788},
        {1'b0,1'b1,1'b0,1'b0,10'h023,3'd0,3'd7,4'd0,64'h0},
        {1'b1,1'b1,1'b0,1'b1,10'h068,3'd0,3'd3,4'd0,64'h00000000000000C3},
        {1'b1,1'b1,1'b0,1'b0,10'h011,3'd1,3'd1,4'd0,64'h000000000000BEEF},
        {1'b1,1'b0,1'b1,1'b0,10'h2A5,3'd7,3'd0,4'd0,64'hF0E1D2C3B4A59687},
        {1'b0,1'b1,1'b1,1'b0,10'h3C1,3'd0,3'd0,4'd0,64'h0},
        {1'b1,1'b0,1'b0,1'b0,10'h040,3'd3,3'd0,4'd1,64'h0102030405060708},
        {1'b1,1'b0,1'b0,1'b0,10'h040,3'd3,3'd0,4'd3,64'hAABBCCDDEEFF0011},
        {1'b0,1'b1,1'b0,1'b0,10'h010,3'd0,3'd2,4'd1,64'h0}
    };

    // bus model: answers each command after one idle cycle
    initial begin
        resp_valid = 1'b0; resp_ack = 1'b0; resp_byte = 8'h00;
        forever begin
            @(negedge clk);
            if (cmd_valid && !rst && !resp_valid) begin
                logic       a;
                logic [7:0] d;
                a = 1'b1; d = 8'h00;
                if (logn < 64) begin
                    logop[logn]   = cmd_op;
                    logbyte[logn] = (cmd_op == OP_WRITE) ? cmd_byte : 8'h00;
                    logn++;
                end
                if (cmd_op == OP_WRITE) begin
                    wrcnt++;
                    a = (wrcnt != nack_at);
                end
                if (cmd_op == OP_READ_ACK || cmd_op == OP_READ_NACK) begin
                    d = 8'h80 + 8'(rdcnt);
                    rdcnt++;
                end
                @(negedge clk);
                resp_valid = 1'b1; resp_ack = a; resp_byte = d;
                @(negedge clk);
                resp_valid = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic ctl_write(input logic [31:0] w);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = w;
        @(negedge clk);
        ctl_we = 1'b0; ctl_wdata = '0;
    endtask

    task automatic wait_cause();
        int n = 0;
        while (!cause && n < 3000) begin
            @(negedge clk);
            n++;
        end
    endtask

    function automatic logic [7:0] hdr(input logic ten, input logic [9:0] a, input logic dir);
        return ten ? {5'b11110, a[9:8], dir} : {a[6:0], dir};
    endfunction

    task automatic add_exp(input logic [2:0] op, input logic [7:0] b);
        if (!ended) begin
            expop[expn] = op; expbyte[expn] = b; expn++;
            if (op == OP_WRITE) begin
                expw++;
                if (expw == nack_at) begin
                    expop[expn] = OP_STOP; expbyte[expn] = 8'h00; expn++;
                    ended = 1'b1;
                end
            end
        end
    endtask

    task automatic build_exp(input logic [87:0] v);
        logic wr, rd, ten, rs;
        logic [9:0] a;
        logic [2:0] txl, rxl;
        logic [63:0] tx;
        {wr, rd, ten, rs, a, txl, rxl} = v[87:68];
        tx = v[63:0];
        expn = 0; expw = 0; ended = 1'b0;
        add_exp(OP_START, 8'h00);
        if (wr) begin
            add_exp(OP_WRITE, hdr(ten, a, 1'b0));
            if (ten) add_exp(OP_WRITE, a[7:0]);
            for (int k = 0; k <= int'(txl); k++) add_exp(OP_WRITE, tx[8*k +: 8]);
            if (rd) begin
                if (rs) add_exp(OP_RESTART, 8'h00);
                else begin add_exp(OP_STOP, 8'h00); add_exp(OP_START, 8'h00); end
            end
        end
        if (rd) begin
            add_exp(OP_WRITE, hdr(ten, a, 1'b1));
            if (ten) add_exp(OP_WRITE, a[7:0]);
            for (int k = 0; k <= int'(rxl); k++)
                add_exp((k == int'(rxl)) ? OP_READ_NACK : OP_READ_ACK, 8'h00);
        end
        add_exp(OP_STOP, 8'h00);
    endtask

    function automatic logic [31:0] ctl_of(input logic [87:0] v);
        return {11'd0, v[84], 1'b1, v[70:68], v[73:71], v[85], v[83:74], v[86], v[87]};
    endfunction

    function automatic bit log_match();
        if (logn != expn) return 1'b0;
        for (int k = 0; k < expn; k++)
            if (logop[k] != expop[k] || logbyte[k] != expbyte[k]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic prep(input logic [87:0] v);
        tx_lo = v[31:0]; tx_hi = v[63:32];
        nack_at = int'(v[67:64]);
        logn = 0; wrcnt = 0; rdcnt = 0;
        build_exp(v);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [63:0] exp_rx;
        rst = 1'b1; ctl_we = 1'b0; ctl_wdata = '0; tx_lo = '0; tx_hi = '0;
        logn = 0; wrcnt = 0; rdcnt = 0; nack_at = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: reset state
        chk(!busy && !cause && !status_err && !cmd_valid, "R12 flags",
            {60'd0, busy, cause, status_err, cmd_valid}, 64'd0);
        chk({rx_hi, rx_lo} == 64'd0, "R12 rx", {rx_hi, rx_lo}, 64'd0);

        // table walk: R1 R3 R4 R5 R6 R7 R8 R10
        for (int i = 0; i < NV; i++) begin
            prep(VEC[i]);
            ctl_write(ctl_of(VEC[i]));
            wait_cause();
            @(negedge clk);
            chk(cause && !busy, $sformatf("R7 done v%0d", i), {62'd0, cause, busy}, 64'd2);
            chk(status_err == (nack_at != 0), $sformatf("R8 err v%0d", i),
                {63'd0, status_err}, {63'd0, (nack_at != 0)});
            chk(log_match(), $sformatf("R3/R4/R6 command log v%0d", i), 64'(logn), 64'(expn));
            exp_rx = '0;
            if (VEC[i][86] && nack_at == 0)
                for (int k = 0; k <= int'(VEC[i][70:68]); k++) exp_rx[8*k +: 8] = 8'h80 + 8'(k);
            chk({rx_hi, rx_lo} == exp_rx, $sformatf("R5 rx v%0d", i), {rx_hi, rx_lo}, exp_rx);
            ctl_write(32'd0);
            @(negedge clk);
            chk(!cause && !status_err, $sformatf("R10 clear v%0d", i),
                {62'd0, cause, status_err}, 64'd0);
        end

        // R9: control write while busy is ignored
        prep(VEC[0]);
        ctl_write(ctl_of(VEC[0]));
        repeat (3) @(negedge clk);
        ctl_write(ctl_of(VEC[1]));
        wait_cause();
        @(negedge clk);
        chk(log_match(), "R9 write while busy", 64'(logn), 64'(expn));
        chk({rx_hi, rx_lo} == 64'd0, "R9 rx untouched", {rx_hi, rx_lo}, 64'd0);

        // R9: control write while cause pending is ignored
        logn = 0;
        ctl_write(ctl_of(VEC[1]));
        repeat (12) @(negedge clk);
        chk(!busy && logn == 0 && cause, "R9 write while cause set",
            {32'(logn), 31'd0, busy}, 64'd0);
        ctl_write(32'd0);

        // R11: enable bit clear
        logn = 0;
        ctl_write(ctl_of(VEC[0]) & ~(32'd1 << 19));
        repeat (12) @(negedge clk);
        chk(!busy && !cause && logn == 0, "R11 enable clear", {32'(logn), 30'd0, busy, cause}, 64'd0);

        // R11: no phase selected
        ctl_write(32'h0008_0000 | (32'h55 << 2));
        repeat (12) @(negedge clk);
        chk(!busy && !cause && logn == 0, "R11 no phase", {32'(logn), 30'd0, busy, cause}, 64'd0);

        // R2: bus sees nothing while idle
        chk(!cmd_valid, "R2 idle bus", {63'd0, cmd_valid}, 64'd0);

        summary();
        $finish;
    end

endmodule